// File: doc/BRIEF.md
# Single-Level Section Address Translator

This block turns a 32-bit virtual address into a physical address by reading one section descriptor from a translation table in external memory. The table has 4096 one-word entries. Each entry covers a 1 MB window of the virtual space, and the top twelve address bits select the entry. The requester issues one address on a valid/ready port. The block then fetches the matching descriptor over a plain read-request/read-data port. It returns the physical address with the descriptor's attribute bits, or a fault code when the entry does not describe a section.

When translation is switched off, the virtual address passes straight through. No memory read takes place, and the response appears on the cycle after acceptance. Only one lookup is in flight at a time. The table base and the enable are both sampled when a request is accepted. The attribute bits are passed on to the requester and are never acted on inside the block.

Top module: `sect_xlate`

## Requirements
- R1: With translation on, the read address issued is {base[31:14], va[31:20], 2'b00}. The low fourteen bits of the base input are ignored.
- R2: A descriptor whose bits [1:0] are 2'b10 yields pa = {desc[31:20], va[19:0]} and no fault. The attribute output is {desc[11:10] (access), desc[8:5] (domain), desc[4] (no-execute), desc[3] (cacheable), desc[2] (bufferable)}, most significant first.
- R3: With translation off at acceptance, pa equals va, the fault flag is low, the fault code and attributes are zero, and no read is issued. The response is valid on the cycle after acceptance.
- R4: A descriptor with bits [1:0] = 2'b00, which includes an all-zero entry, faults with code 2'b01. It returns a zero pa and zero attributes.
- R5: A descriptor with bits [1:0] of 2'b01 or 2'b11 faults with code 2'b10. It returns a zero pa and zero attributes.
- R6: Request-ready is high only while idle. It stays low from acceptance until the response handshake completes.
- R7: While the response is valid and not taken, every response field holds steady.
- R8: The read request stays asserted with a steady address until the memory accepts it.
- R9: A change to the base or to the enable while a lookup is in flight affects only later requests.
- R10: A synchronous active-low reset leaves the block idle, with request-ready high and neither a response nor a read request pending.
- R11: Read-data-valid is ignored unless the block is waiting for a descriptor.
- R12: The response becomes valid on the cycle after read data is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xlat_en | input | 1 | Translation on (1) or flat pass-through (0) |
| tbl_base | input | 32 | Translation table base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 1 | Translation fault |
| rsp_fcode | output | 2 | Fault code: 01 invalid, 10 unsupported type |
| rsp_attr | output | 9 | Access, domain, no-execute, cacheable, bufferable |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rdata_valid | input | 1 | Descriptor data valid |
| mem_rdata | input | 32 | Descriptor data |

## Verification
The hardest case to produce is a change to the table base or the enable that lands while a lookup is still in flight. If the block read those inputs late, it would fetch from the wrong table or skip the fetch altogether. The stimulus accepts a request against one table, then switches the base to a second table that holds a different entry at the same index, or turns translation off, on the very next cycle. The memory model delays both its acceptance and its data, so the changed inputs sit unchanged across several cycles of the lookup. Separately, stray read-data pulses are injected while the block is idle and while a read request is still unacknowledged, and a reset is applied in the middle of a fetch.

// File: rtl/sect_xlate.sv
`timescale 1ns/1ps
module sect_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xlat_en,
  input  logic [31:0] tbl_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_pa,
  output logic        rsp_fault,
  output logic [1:0]  rsp_fcode,
  output logic [8:0]  rsp_attr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_addr,
  input  logic        mem_rdata_valid,
  input  logic [31:0] mem_rdata
);
  localparam logic [1:0] FC_NONE  = 2'b00;
  localparam logic [1:0] FC_INVAL = 2'b01;
  localparam logic [1:0] FC_TYPE  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_RESP} st_t;
  st_t st;

  logic [19:0] off_q;
  logic [31:0] addr_q, pa_q;
  logic [1:0]  fc_q;
  logic [8:0]  attr_q;

  wire accept = req_valid && req_ready;
  wire unused_bits = ^{tbl_base[13:0], mem_rdata[19:12], mem_rdata[9]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      off_q  <= '0;
      addr_q <= '0;
      pa_q   <= '0;
      fc_q   <= FC_NONE;
      attr_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          off_q <= req_va[19:0];
          if (!xlat_en) begin
            pa_q   <= req_va;
            fc_q   <= FC_NONE;
            attr_q <= '0;
            st     <= S_RESP;
          end else begin
            addr_q <= {tbl_base[31:14], req_va[31:20], 2'b00};
            st     <= S_FETCH;
          end
        end
        S_FETCH: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rdata_valid) begin
          case (mem_rdata[1:0])
            2'b10: begin
              pa_q   <= {mem_rdata[31:20], off_q};
              fc_q   <= FC_NONE;
              attr_q <= {mem_rdata[11:10], mem_rdata[8:5], mem_rdata[4:2]};
            end
            2'b00: begin
              pa_q   <= '0;
              fc_q   <= FC_INVAL;
              attr_q <= '0;
            end
            default: begin
              pa_q   <= '0;
              fc_q   <= FC_TYPE;
              attr_q <= '0;
            end
          endcase
          st <= S_RESP;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_FETCH);
  assign mem_addr      = addr_q;
  assign rsp_valid     = (st == S_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_fcode     = fc_q;
  assign rsp_fault     = (fc_q != FC_NONE);
  assign rsp_attr      = attr_q;

  a_r10_reset_idle: assert property (@(posedge clk)
    !rst_n |=> req_ready && !rsp_valid && !mem_req_valid);

  a_r1_desc_addr: assert property (@(posedge clk) disable iff (!rst_n)
    accept && xlat_en |=> mem_req_valid &&
      mem_addr == {$past(tbl_base[31:14]), $past(req_va[31:20]), 2'b00});

  a_r3_flat_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !xlat_en |=> rsp_valid && !mem_req_valid &&
      rsp_pa == $past(req_va) && !rsp_fault && rsp_attr == 9'd0);

  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) &&
      $stable(rsp_fcode) && $stable(rsp_attr));

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

  a_r4_r5_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == 32'd0 && rsp_attr == 9'd0 &&
      rsp_fcode != 2'b11);

  a_r12_rsp_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_valid && !rsp_valid && !req_ready && mem_rdata_valid |=> rsp_valid);
endmodule

// File: tb/tb_sect_xlate.sv
`timescale 1ns/1ps
module tb_sect_xlate;
  logic clk = 0, rst_n = 0, xlat_en = 0, req_valid = 0, rsp_ready = 0;
  logic [31:0] tbl_base = 0, req_va = 0;
  logic mem_req_ready = 0, mem_rdata_valid = 0;
  logic [31:0] mem_rdata = 0;
  logic req_ready, rsp_valid, rsp_fault, mem_req_valid;
  logic [31:0] rsp_pa, mem_addr;
  logic [1:0] rsp_fcode;
  logic [8:0] rsp_attr;

  always #4 clk = ~clk;

  sect_xlate dut (.clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault), .rsp_fcode(rsp_fcode), .rsp_attr(rsp_attr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata));

  int compared = 0, mismatched = 0;
  string ctx = "reset";
  logic [31:0] table_mem [int unsigned];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s (%s) at %0t: actual=%h expected=%h", tag, ctx, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_table(input logic [31:0] a);
    return table_mem.exists(a) ? table_mem[a] : 32'd0;
  endfunction

  // reference model
  int ph = 0;
  bit go = 0;
  logic [31:0] e_addr, e_pa;
  logic [1:0] e_fc;
  logic [8:0] e_attr;
  string e_tag;
  initial begin @(posedge clk); go = 1; end

  always @(negedge clk) if (go) begin
    chk("R6", req_ready, ph == 0);
    chk("R3 R12", rsp_valid, ph == 3);
    chk("R8", mem_req_valid, ph == 1);
    if (ph == 1) chk("R1 R8", mem_addr, e_addr);
    if (ph == 3) begin
      chk({e_tag, " R7 pa"}, rsp_pa, e_pa);
      chk({e_tag, " R7 fault/code/attr"}, {rsp_fault, rsp_fcode, rsp_attr},
          {e_fc != 2'b00, e_fc, e_attr});
    end
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (req_valid) begin
        if (!xlat_en) begin
          e_pa = req_va; e_fc = 2'b00; e_attr = 0; e_tag = "R3"; ph = 3;
        end else begin
          logic [31:0] d;
          e_addr = {tbl_base[31:14], req_va[31:20], 2'b00};
          d = rd_table(e_addr);
          if (d[1:0] == 2'b10) begin
            e_pa = {d[31:20], req_va[19:0]}; e_fc = 2'b00;
            e_attr = {d[11:10], d[8:5], d[4], d[3], d[2]}; e_tag = "R2";
          end else if (d[1:0] == 2'b00) begin
            e_pa = 0; e_fc = 2'b01; e_attr = 0; e_tag = "R4";
          end else begin
            e_pa = 0; e_fc = 2'b10; e_attr = 0; e_tag = "R5";
          end
          ph = 1;
        end
      end
      1: if (mem_req_ready) ph = 2;
      2: if (mem_rdata_valid) ph = 3;
      default: if (rsp_ready) ph = 0;
    endcase
  end

  // memory responder
  int ready_lag = 0, data_lag = 0;
  bit spur = 0;
  initial begin
    bit pend = 0;
    int rcnt = 0, dcnt = 0;
    logic [31:0] paddr = 0;
    forever begin
      @(posedge clk); #1;
      if (!rst_n) begin
        pend = 0; rcnt = 0; mem_req_ready = 0; mem_rdata_valid = 0;
      end else begin
        if (mem_req_ready) begin pend = 1; dcnt = data_lag; end
        mem_rdata_valid = spur;
        if (spur) mem_rdata = 32'h0AA0_0DEE;
        if (pend) begin
          if (dcnt == 0) begin
            mem_rdata_valid = 1; mem_rdata = rd_table(paddr); pend = 0;
          end else dcnt--;
        end
        mem_req_ready = mem_req_valid && !mem_req_ready && rcnt >= ready_lag;
        if (mem_req_ready) paddr = mem_addr;
        rcnt = mem_req_valid ? rcnt + 1 : 0;
      end
    end
  end

  task automatic xlat(input logic [31:0] va, input int hold,
                      input bit chg, input logic [31:0] nbase, input bit nen);
    @(posedge clk); #1; req_valid = 1; req_va = va;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1; req_valid = 0;
    if (chg) begin tbl_base = nbase; xlat_en = nen; end
    do @(negedge clk); while (!rsp_valid);
    for (int i = 0; i < hold; i++) @(posedge clk);
    @(posedge clk); #1; rsp_ready = 1;
    @(posedge clk); #1; rsp_ready = 0;
  endtask

  localparam logic [31:0] B1 = 32'h1234_4000;
  localparam logic [31:0] B2 = 32'h0008_0000;

  initial begin
    table_mem[B1 + 32'h8]   = 32'h0080_0DEE;
    for (int k = 0; k < 4; k++)
      table_mem[B1 + 32'h400 + 4*k] = 32'h9000_0012 + (k << 20);
    table_mem[B1 + 32'h20]  = 32'hABC0_0001;
    table_mem[B1 + 32'h24]  = 32'hABC0_0003;
    table_mem[B1 + 32'h3FFC] = 32'hFFF0_0412;
    table_mem[B2 + 32'h8]   = 32'h0550_0002;

    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    ctx = "R10 after reset";
    chk("R10 req_ready", req_ready, 1);
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 mem_req_valid", mem_req_valid, 0);

    ctx = "R3 flat";
    xlat(32'h3EF0_1234, 0, 0, 0, 0);
    xlat(32'hFFFF_FFFF, 2, 0, 0, 0);
    xlat(32'h0000_0000, 0, 0, 0, 0);

    ctx = "R2 section";
    tbl_base = B1; xlat_en = 1;
    xlat(32'h0020_0404, 0, 0, 0, 0);
    chk("R2 example pa", rsp_pa, 32'h0080_0404);
    xlat(32'hFFFF_FFFF, 0, 0, 0, 0);
    ctx = "R2 four consecutive 1MB entries";
    for (int k = 0; k < 4; k++) xlat({12'h100 + 12'(k), 20'hABCDE}, 0, 0, 0, 0);

    ctx = "R1 base low bits ignored";
    tbl_base = B1 | 32'h3ABC;
    xlat(32'h0020_0001, 0, 0, 0, 0);
    tbl_base = B1;

    ctx = "R4 zero entry";
    xlat(32'h0070_0010, 0, 0, 0, 0);
    ctx = "R5 type 01";
    xlat(32'h0080_0000, 0, 0, 0, 0);
    ctx = "R5 type 11";
    xlat(32'h0090_0000, 0, 0, 0, 0);

    ctx = "R7 R8 stalls";
    ready_lag = 4; data_lag = 3;
    xlat(32'h0020_0404, 5, 0, 0, 0);
    xlat(32'h0070_0000, 3, 0, 0, 0);

    ctx = "R9 base change in flight";
    xlat(32'h0020_0404, 0, 1, B2, 1);
    xlat(32'h0020_0404, 0, 0, 0, 0);
    chk("R9 new base used next", rsp_pa, 32'h0550_0404);
    ctx = "R9 enable change in flight";
    xlat(32'h0020_0404, 0, 1, B2, 0);
    xlat(32'h0020_0404, 0, 0, 0, 0);
    chk("R9 flat after disable", rsp_pa, 32'h0020_0404);

    ctx = "R11 stray data while idle";
    @(posedge clk); #1; spur = 1;
    @(posedge clk); #1; spur = 0;
    repeat (2) @(negedge clk);
    chk("R11 idle unaffected", {req_ready, rsp_valid}, 2'b10);
    ctx = "R11 stray data during fetch";
    xlat_en = 1; tbl_base = B1; ready_lag = 6; data_lag = 0;
    @(posedge clk); #1; req_valid = 1; req_va = 32'h0070_0000;
    @(posedge clk); #1; req_valid = 0;
    repeat (2) @(posedge clk); #1; spur = 1;
    @(posedge clk); #1; spur = 0;
    do @(negedge clk); while (!rsp_valid);
    chk("R11 fault code kept", rsp_fcode, 2'b01);
    @(posedge clk); #1; rsp_ready = 1;
    @(posedge clk); #1; rsp_ready = 0;

    ctx = "R10 reset mid-fetch";
    @(posedge clk); #1; req_valid = 1; req_va = 32'h0020_0404;
    @(posedge clk); #1; req_valid = 0;
    @(posedge clk); #1; rst_n = 0;
    repeat (2) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk("R10 idle after reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    ready_lag = 0;
    ctx = "R12 after reset";
    xlat(32'h0020_0404, 0, 0, 0, 0);

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog (%s): actual=hung expected=done", ctx);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule